// File: doc/BRIEF.md
# S/PDIF Channel Status and User Data Sequencer

This block stores the channel status bits and the user data bits of one S/PDIF block, separately for the left and right channels. It hands the transmit serializer the right pair of bits for every subframe. A block has 192 frames. Each frame has a left subframe followed by a right subframe. The block keeps four banks of six 32-bit words each: left status, right status, left user data and right user data. That is 192 bits per bank, one bit per frame.

The serializer pulses `sf_stb` once per subframe, and `sf_right` tells the block which subframe it is. One cycle later the block presents the status bit and the user bit for that subframe and the current frame. The frame counter advances when the right subframe is taken. A one-cycle `block_end` pulse marks the end of frame 191, and the counter then returns to frame 0.

The banks are single-buffered, so a write changes the live bits at once. The current frame and the 32-bit word that holds its bits are visible on ports at all times. Software can therefore rewrite any word except the one in use. If software writes the word in use, the block may send either the old bit or the new bit for that frame.

The sequencer is a two-state machine:
- `ST_WAIT_LEFT` waits for the left subframe.
- `ST_WAIT_RIGHT` waits for the right subframe.

It has four named transitions:
- LEFT_TAKEN: a left strobe in `ST_WAIT_LEFT` moves to `ST_WAIT_RIGHT`.
- RIGHT_TAKEN: a right strobe in `ST_WAIT_RIGHT` moves back to `ST_WAIT_LEFT` and advances the frame.
- LEFT_REPEAT: a left strobe in `ST_WAIT_RIGHT` stays put and re-sends the left bits.
- RIGHT_STRAY: a right strobe in `ST_WAIT_LEFT` stays put and is dropped.

Top module: `spdif_cu_seq`

## Requirements
- R1: After a synchronous reset, `frame_idx` is 0, `word_idx` is 0, `bit_valid` and `block_end` are 0, and every register address reads 0.
- R2: The register address holds the bank in bits [4:3] and the word in bits [2:0]. The banks are 0 = left status, 1 = right status, 2 = left user data and 3 = right user data. Words 0 to 5 are writable and read back on `reg_rdata` from the cycle after the write. Writes to words 6 and 7 are ignored, and those words read 0.
- R3: The bit sent for frame f is bit (f mod 32) of word (f / 32) of the selected bank.
- R4: A left strobe (`sf_stb`=1, `sf_right`=0) in `ST_WAIT_LEFT` gives, one cycle later, `bit_valid`=1 and `bit_right`=0. `cs_bit` and `ud_bit` then carry the left-bank bits of the current frame, and `frame_idx` is unchanged.
- R5: A right strobe in `ST_WAIT_RIGHT` gives, one cycle later, `bit_valid`=1, `bit_right`=1 and the right-bank bits of the frame before the advance. In that same cycle `frame_idx` has advanced by 1.
- R6: Taking the right subframe of frame 191 returns `frame_idx` to 0 and pulses `block_end` high for exactly the cycle in which that right bit is presented. `frame_idx` never exceeds 191.
- R7: A right strobe in `ST_WAIT_LEFT` produces no `bit_valid` and leaves the frame unchanged. A left strobe in `ST_WAIT_RIGHT` re-sends the left bits of the same frame without advancing.
- R8: `word_idx` always equals `frame_idx` / 32.
- R9: Writing one word, including the word in use, leaves every other word of every bank unchanged.
- R10: `bit_valid` is high only in the cycle after an accepted strobe and is low after a cycle without one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| reg_wr | input | 1 | Register write enable |
| reg_addr | input | 5 | Register address: bank in [4:3], word in [2:0] |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| sf_stb | input | 1 | Subframe strobe from the serializer |
| sf_right | input | 1 | Strobe is for the right subframe (0 = left) |
| cs_bit | output | 1 | Channel status bit for the last accepted subframe |
| ud_bit | output | 1 | User data bit for the last accepted subframe |
| bit_valid | output | 1 | `cs_bit`/`ud_bit` were updated this cycle |
| bit_right | output | 1 | Presented bits belong to the right subframe |
| frame_idx | output | 8 | Current frame, 0 to 191 |
| word_idx | output | 3 | Word holding the current frame's bits |
| block_end | output | 1 | One-cycle pulse after frame 191 is consumed |

## Verification
A frame counter that has slipped shows at once in `frame_idx` and `word_idx`. It also makes every later `cs_bit`/`ud_bit` disagree with the bank contents, beginning at the next accepted strobe. A state machine stuck in the wrong subframe state shows on the next strobe: `bit_valid` is missing, `bit_right` is wrong, or the frame advances at the wrong time. A wrong wrap shows at frame 191 as a misplaced or missing `block_end`. Corrupted bank words show either through `reg_rdata` in the same cycle they are read, or in the bit sent when their frame comes round.

// File: rtl/cud_pkg.sv
package cud_pkg;

    typedef enum logic [1:0] {
        BANK_LC = 2'd0,
        BANK_RC = 2'd1,
        BANK_LU = 2'd2,
        BANK_RU = 2'd3
    } bank_e;

    localparam int NBANK = 4;

    typedef enum logic {
        ST_WAIT_LEFT  = 1'b0,
        ST_WAIT_RIGHT = 1'b1
    } seq_state_e;

    typedef struct packed {
        logic cs;
        logic ud;
    } cu_pair_t;

endpackage

// File: rtl/cud_regfile.sv
module cud_regfile
    import cud_pkg::*;
#(
    parameter int WORD_W  = 32,
    parameter int NWORDS  = 6,
    parameter int WIDX_W  = 3,
    parameter int FRAME_W = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [1:0]           wr_bank,
    input  logic [WIDX_W-1:0]    wr_word,
    input  logic [WORD_W-1:0]    wr_data,
    input  logic [1:0]           rd_bank,
    input  logic [WIDX_W-1:0]    rd_word,
    output logic [WORD_W-1:0]    rd_data,
    input  logic [FRAME_W-1:0]   tap_frame,
    output logic [NBANK-1:0]     tap_bits
);
    localparam int BIT_W = $clog2(WORD_W);

    logic [WORD_W-1:0] words [NBANK][NWORDS];

    logic              wr_ok;
    logic [WIDX_W-1:0] tap_word;
    logic [BIT_W-1:0]  tap_bit;

    assign wr_ok    = wr_en && (int'(wr_word) < NWORDS);
    assign tap_word = tap_frame[FRAME_W-1:BIT_W];
    assign tap_bit  = tap_frame[BIT_W-1:0];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NBANK; b++) begin
                for (int w = 0; w < NWORDS; w++) begin
                    words[b][w] <= '0;
                end
            end
        end else if (wr_ok) begin
            for (int b = 0; b < NBANK; b++) begin
                for (int w = 0; w < NWORDS; w++) begin
                    if (wr_bank == 2'(b) && wr_word == WIDX_W'(w)) begin
                        words[b][w] <= wr_data;
                    end
                end
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int b = 0; b < NBANK; b++) begin
            for (int w = 0; w < NWORDS; w++) begin
                if (rd_bank == 2'(b) && rd_word == WIDX_W'(w)) begin
                    rd_data = words[b][w];
                end
            end
        end
    end

    for (genvar b = 0; b < NBANK; b++) begin : g_tap
        logic [WORD_W-1:0] sel_word;
        always_comb begin
            sel_word = '0;
            for (int w = 0; w < NWORDS; w++) begin
                if (tap_word == WIDX_W'(w)) begin
                    sel_word = words[b][w];
                end
            end
        end
        assign tap_bits[b] = sel_word[tap_bit];
    end

endmodule

// File: rtl/cud_frame_seq.sv
module cud_frame_seq
    import cud_pkg::*;
#(
    parameter int FRAMES  = 192,
    parameter int FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               stb,
    input  logic               right,
    output logic               take_left,
    output logic               take_right,
    output logic               last_frame,
    output logic [FRAME_W-1:0] frame_idx
);
    localparam logic [FRAME_W-1:0] LAST = FRAME_W'(FRAMES - 1);

    seq_state_e         state_q, state_d;
    logic [FRAME_W-1:0] frame_q;

    // state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT_LEFT;
        else     state_q <= state_d;
    end

    // transitions: LEFT_TAKEN, RIGHT_TAKEN, LEFT_REPEAT, RIGHT_STRAY
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT_LEFT:  if (stb && !right) state_d = ST_WAIT_RIGHT;
            ST_WAIT_RIGHT: if (stb && right)  state_d = ST_WAIT_LEFT;
            default:       state_d = ST_WAIT_LEFT;
        endcase
    end

    // outputs
    always_comb begin
        take_left  = 1'b0;
        take_right = 1'b0;
        unique case (state_q)
            ST_WAIT_LEFT: begin
                take_left = stb && !right;
            end
            ST_WAIT_RIGHT: begin
                take_left  = stb && !right;
                take_right = stb && right;
            end
            default: begin
                take_left  = 1'b0;
                take_right = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            frame_q <= '0;
        end else if (take_right) begin
            frame_q <= (frame_q == LAST) ? '0 : frame_q + 1'b1;
        end
    end

    assign last_frame = (frame_q == LAST);
    assign frame_idx  = frame_q;

endmodule

// File: rtl/cud_bit_out.sv
module cud_bit_out
    import cud_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take_left,
    input  logic             take_right,
    input  logic             last_frame,
    input  logic [NBANK-1:0] tap_bits,
    output logic             cs_bit,
    output logic             ud_bit,
    output logic             bit_valid,
    output logic             bit_right,
    output logic             block_end
);
    cu_pair_t pair_q, pair_d;
    logic     valid_q, right_q, end_q;

    always_comb begin
        pair_d = pair_q;
        if (take_right) begin
            pair_d.cs = tap_bits[BANK_RC];
            pair_d.ud = tap_bits[BANK_RU];
        end else if (take_left) begin
            pair_d.cs = tap_bits[BANK_LC];
            pair_d.ud = tap_bits[BANK_LU];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q  <= '0;
            valid_q <= 1'b0;
            right_q <= 1'b0;
            end_q   <= 1'b0;
        end else begin
            pair_q  <= pair_d;
            valid_q <= take_left || take_right;
            if (take_left || take_right) right_q <= take_right;
            end_q   <= take_right && last_frame;
        end
    end

    assign cs_bit    = pair_q.cs;
    assign ud_bit    = pair_q.ud;
    assign bit_valid = valid_q;
    assign bit_right = right_q;
    assign block_end = end_q;

endmodule

// File: rtl/spdif_cu_seq.sv
module spdif_cu_seq
    import cud_pkg::*;
#(
    parameter int FRAMES  = 192,
    parameter int WORD_W  = 32,
    parameter int FRAME_W = $clog2(FRAMES),
    parameter int BIT_W   = $clog2(WORD_W),
    parameter int WIDX_W  = FRAME_W - BIT_W,
    parameter int ADDR_W  = 2 + WIDX_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               reg_wr,
    input  logic [ADDR_W-1:0]  reg_addr,
    input  logic [WORD_W-1:0]  reg_wdata,
    output logic [WORD_W-1:0]  reg_rdata,
    input  logic               sf_stb,
    input  logic               sf_right,
    output logic               cs_bit,
    output logic               ud_bit,
    output logic               bit_valid,
    output logic               bit_right,
    output logic [FRAME_W-1:0] frame_idx,
    output logic [WIDX_W-1:0]  word_idx,
    output logic               block_end
);
    localparam int NWORDS = (FRAMES + WORD_W - 1) / WORD_W;

    logic             take_left, take_right, last_frame;
    logic [NBANK-1:0] tap_bits;

    cud_frame_seq #(
        .FRAMES (FRAMES),
        .FRAME_W(FRAME_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .stb       (sf_stb),
        .right     (sf_right),
        .take_left (take_left),
        .take_right(take_right),
        .last_frame(last_frame),
        .frame_idx (frame_idx)
    );

    cud_regfile #(
        .WORD_W (WORD_W),
        .NWORDS (NWORDS),
        .WIDX_W (WIDX_W),
        .FRAME_W(FRAME_W)
    ) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .wr_bank  (reg_addr[ADDR_W-1 -: 2]),
        .wr_word  (reg_addr[WIDX_W-1:0]),
        .wr_data  (reg_wdata),
        .rd_bank  (reg_addr[ADDR_W-1 -: 2]),
        .rd_word  (reg_addr[WIDX_W-1:0]),
        .rd_data  (reg_rdata),
        .tap_frame(frame_idx),
        .tap_bits (tap_bits)
    );

    cud_bit_out u_out (
        .clk       (clk),
        .rst       (rst),
        .take_left (take_left),
        .take_right(take_right),
        .last_frame(last_frame),
        .tap_bits  (tap_bits),
        .cs_bit    (cs_bit),
        .ud_bit    (ud_bit),
        .bit_valid (bit_valid),
        .bit_right (bit_right),
        .block_end (block_end)
    );

    assign word_idx = frame_idx[FRAME_W-1:BIT_W];

endmodule

// File: rtl/cud_checker.sv
module cud_checker #(
    parameter int FRAMES  = 192,
    parameter int FRAME_W = 8,
    parameter int WIDX_W  = 3,
    parameter int NWORDS  = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               sf_stb,
    input logic [FRAME_W-1:0] frame_idx,
    input logic [WIDX_W-1:0]  word_idx,
    input logic               bit_valid,
    input logic               bit_right,
    input logic               block_end
);
    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (frame_idx == '0 && !bit_valid && !block_end));

    assert_left_no_advance_R4: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && !bit_right) |-> $stable(frame_idx));

    assert_right_advance_R5: assert property (@(posedge clk) disable iff (rst)
        (bit_valid && bit_right && !block_end)
            |-> (frame_idx == FRAME_W'($past(frame_idx) + 1'b1)));

    assert_wrap_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        block_end |-> (bit_valid && bit_right && frame_idx == '0
                       && $past(frame_idx) == FRAME_W'(FRAMES - 1)));

    assert_frame_range_R6: assert property (@(posedge clk) disable iff (rst)
        int'(frame_idx) < FRAMES);

    assert_stray_hold_R7: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> $stable(frame_idx));

    assert_word_range_R8: assert property (@(posedge clk) disable iff (rst)
        int'(word_idx) < NWORDS);

    assert_valid_cause_R10: assert property (@(posedge clk) disable iff (rst)
        bit_valid |-> $past(sf_stb));

endmodule

bind spdif_cu_seq cud_checker #(
    .FRAMES (FRAMES),
    .FRAME_W(FRAME_W),
    .WIDX_W (WIDX_W),
    .NWORDS ((FRAMES + WORD_W - 1) / WORD_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sf_stb   (sf_stb),
    .frame_idx(frame_idx),
    .word_idx (word_idx),
    .bit_valid(bit_valid),
    .bit_right(bit_right),
    .block_end(block_end)
);

// File: tb/spdif_cu_seq_tb.sv
`timescale 1ns/1ps
module spdif_cu_seq_tb;
    localparam int FRAMES = 192;

    logic        clk = 1'b0;
    logic        rst;
    logic        reg_wr;
    logic [4:0]  reg_addr;
    logic [31:0] reg_wdata, reg_rdata;
    logic        sf_stb, sf_right;
    logic        cs_bit, ud_bit, bit_valid, bit_right, block_end;
    logic [7:0]  frame_idx;
    logic [2:0]  word_idx;

    always #2.5 clk = ~clk;

    spdif_cu_seq u_dut (
        .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .sf_stb(sf_stb),
        .sf_right(sf_right), .cs_bit(cs_bit), .ud_bit(ud_bit),
        .bit_valid(bit_valid), .bit_right(bit_right), .frame_idx(frame_idx),
        .word_idx(word_idx), .block_end(block_end)
    );

    bit [31:0] mdl [4][8];
    int  mframe;
    bit  mwait_right;
    int  errors = 0;
    int  checks = 0;
    int  ends_seen = 0;
    bit  done = 1'b0;

    function automatic bit exp_bit(int bank, int f);
        return mdl[bank][f / 32][f % 32];
    endfunction

    function automatic logic [31:0] exp_read(logic [4:0] a);
        if (a[2:0] > 3'd5) return 32'h0;
        return mdl[a[4:3]][a[2:0]];
    endfunction

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cycle(bit stb, bit right, bit wr, logic [4:0] addr, logic [31:0] data);
        bit tl, tr, hazard;
        int f;
        @(negedge clk);
        sf_stb = stb; sf_right = right; reg_wr = wr; reg_addr = addr; reg_wdata = data;
        @(posedge clk);
        #1;
        f  = mframe;
        tl = stb && !right;
        tr = stb && right && mwait_right;
        hazard = wr && (int'(addr[2:0]) == f / 32);
        if (stb && right && !mwait_right) begin
            chk("R7 stray right strobe no valid", 32'(bit_valid), 32'd0);
        end else if (tl && mwait_right) begin
            chk("R7 repeated left valid", 32'(bit_valid), 32'd1);
        end else begin
            chk("R10 bit_valid", 32'(bit_valid), 32'(tl || tr));
        end
        if (tl) begin
            chk("R4 bit_right", 32'(bit_right), 32'd0);
            if (!hazard) begin
                chk("R3 R4 left cs", 32'(cs_bit), 32'(exp_bit(0, f)));
                chk("R3 R4 left ud", 32'(ud_bit), 32'(exp_bit(2, f)));
            end
            mwait_right = 1'b1;
        end else if (tr) begin
            chk("R5 bit_right", 32'(bit_right), 32'd1);
            if (!hazard) begin
                chk("R3 R5 right cs", 32'(cs_bit), 32'(exp_bit(1, f)));
                chk("R3 R5 right ud", 32'(ud_bit), 32'(exp_bit(3, f)));
            end
            chk("R6 block_end", 32'(block_end), 32'(f == FRAMES - 1));
            if (f == FRAMES - 1) ends_seen++;
            mframe = (f + 1) % FRAMES;
            mwait_right = 1'b0;
        end else begin
            chk("R6 no block_end", 32'(block_end), 32'd0);
        end
        if (wr && addr[2:0] <= 3'd5) mdl[addr[4:3]][addr[2:0]] = data;
        chk("R5 frame_idx", 32'(frame_idx), 32'(mframe));
        chk("R8 word_idx", 32'(word_idx), 32'(mframe / 32));
    endtask

    task automatic rd_check(logic [4:0] a, string req);
        @(negedge clk);
        sf_stb = 0; reg_wr = 0; reg_addr = a;
        #1;
        chk(req, reg_rdata, exp_read(a));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int b = 0; b < 4; b++) for (int w = 0; w < 8; w++) mdl[b][w] = '0;
        mframe = 0; mwait_right = 1'b0;
        rst = 1; reg_wr = 0; reg_addr = 0; reg_wdata = 0; sf_stb = 0; sf_right = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;
        #1;
        // R1 reset state
        chk("R1 frame_idx", 32'(frame_idx), 32'd0);
        chk("R1 word_idx", 32'(word_idx), 32'd0);
        chk("R1 bit_valid", 32'(bit_valid), 32'd0);
        chk("R1 block_end", 32'(block_end), 32'd0);
        for (int a = 0; a < 32; a++) rd_check(5'(a), "R1 reset read");

        // R2 write every word, then read back, then try words 6 and 7
        for (int a = 0; a < 32; a++)
            cycle(1'b0, 1'b0, 1'b1, 5'(a), $urandom);
        for (int a = 0; a < 32; a++) rd_check(5'(a), "R2 readback");

        // R3 directed: left C word0 alternating pattern, walk a few frames
        cycle(1'b0, 1'b0, 1'b1, 5'd0, 32'h0000_0005);
        cycle(1'b0, 1'b0, 1'b1, 5'd16, 32'hFFFF_FFFA);
        for (int i = 0; i < 4; i++) begin
            cycle(1'b1, 1'b0, 1'b0, 5'd0, 32'h0);
            cycle(1'b1, 1'b1, 1'b0, 5'd0, 32'h0);
        end

        // R7 directed: stray right, then repeated left
        cycle(1'b1, 1'b1, 1'b0, 5'd0, 32'h0);
        cycle(1'b1, 1'b0, 1'b0, 5'd0, 32'h0);
        cycle(1'b1, 1'b0, 1'b0, 5'd0, 32'h0);
        cycle(1'b1, 1'b1, 1'b0, 5'd0, 32'h0);

        // R9 directed: write the active word of right status, others intact
        cycle(1'b0, 1'b0, 1'b1, {2'd1, 3'(mframe / 32)}, 32'hDEAD_BEEF);
        for (int w = 0; w < 8; w++) rd_check({2'd1, 3'(w)}, "R9 neighbour words");
        for (int w = 0; w < 8; w++) rd_check({2'd0, 3'(w)}, "R9 other bank");

        // random traffic across several blocks
        for (int i = 0; i < 2400; i++) begin
            bit stb, right, wr;
            stb   = ($urandom % 10) < 7;
            right = (($urandom % 10) < 9) ? mwait_right : !mwait_right;
            wr    = ($urandom % 10) == 0;
            cycle(stb, right, wr, 5'($urandom), $urandom);
        end
        // finish the current block deterministically
        while (!(mframe == 0 && !mwait_right && ends_seen >= 2)) begin
            cycle(1'b1, mwait_right, 1'b0, 5'd0, 32'h0);
        end
        chk("R6 blocks completed", 32'(ends_seen >= 2), 32'd1);
        cycle(1'b0, 1'b0, 1'b0, 5'd0, 32'h0);
        chk("R10 idle valid low", 32'(bit_valid), 32'd0);
        for (int a = 0; a < 32; a++) rd_check(5'(a), "R2 R9 final readback");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule